// File: doc/BRIEF.md
# Indirect interrupt routing register file

This block holds the programmable routing state for a bank of interrupt inputs. A host reaches it through two 32-bit locations. One location holds an index, and the other is a data window onto whichever internal register that index names. Behind the window sit the following registers:

- an identification register;
- a read-only capability register that reports the version code and the highest table index;
- an arbitration-ID register;
- a table of 64-bit routing entries, each reached as two adjacent 32-bit halves.

Every table entry is driven out in parallel on a flat bus, so that downstream dispatch logic can read vector, delivery mode, destination and mask for every input without going through the host port. Writes land on the clock edge that ends the access. Reads are combinational within the same bus cycle. Stored reserved bits are always zero.

Top module: `irq_route_regfile`

## Requirements
- R1: A bus access is legal only when `bus_bytes_i` is 4 and `bus_addr_i` is 0 or 16. Any other valid access raises `bus_err_o` in the same cycle, returns zero read data and changes no state.
- R2: A legal write to offset 0 stores `bus_wdata_i[7:0]` as the select index. A legal read of offset 0 returns the index zero-extended to 32 bits. The index resets to 0.
- R3: Index 0 holds a 4-bit ID in bits 27:24, and all its other bits read as zero. The ID resets to parameter `RESET_ID` and is written from `bus_wdata_i[27:24]`.
- R4: Index 1 reads as {8'h00, NUM_ENTRIES-1, 8'h00, VERSION} (VERSION defaults to 8'h11). Writes to index 1 have no effect.
- R5: Index 2 holds a 4-bit arbitration ID in bits 27:24, and all its other bits read as zero. It resets to `RESET_ID` and is written from `bus_wdata_i[27:24]`.
- R6: Index 0x10+2n maps to bits 31:0 of entry n, and index 0x10+2n+1 maps to bits 63:32. A write updates only that half, on the next clock edge. `entries_o[64n+63:64n]` always shows entry n.
- R7: On a write, bits outside 32'h0001_AFFF are cleared in a lower half, and bits outside 32'hFF00_0000 are cleared in an upper half. The lower-half fields are vector 7:0, mode 10:8, destination mode 11, polarity 13, trigger 15 and mask 16. The upper half keeps destination 63:56.
- R8: After reset every entry equals 64'h0000_0000_0001_0000, meaning only the mask bit is set.
- R9: An index of 3..15 or 0x10+2*NUM_ENTRIES and above is undefined. A window access to it reads zero, changes no state and raises `undef_reg_o` for that cycle without raising `bus_err_o`.
- R10: Read data for both offsets is valid combinationally in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset within the block |
| bus_bytes_i | input | 3 | Access size in bytes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| bus_err_o | output | 1 | Illegal offset or size |
| undef_reg_o | output | 1 | Window access to an undefined index |
| entries_o | output | 64*NUM_ENTRIES | All routing entries, entry n at bits 64n+63:64n |

## Verification
The following are checked by assertions on every cycle:
- illegal sizes always flag an error with zero data;
- erroneous and undefined accesses leave the table unchanged across the edge;
- reserved entry bits are never set;
- capability and select reads return their fixed or tracked values.

The bench scenarios are needed for the rest, because they depend on a sequence of select and window accesses:
- the exact mapping of each index to its entry half;
- reset values;
- the masking of writes to the ID fields;
- boundary indices at the table's last half and first undefined index.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [31:0] LO_KEEP   = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP   = 32'hFF00_0000;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam logic [7:0]  IDX_TAB   = 8'h10;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_TAB,
    K_UNDEF
  } reg_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        bytes_i,
  output logic              sel_hit_o,
  output logic              win_hit_o,
  output logic              err_o
);
  logic legal_size;

  assign legal_size = (bytes_i == 3'd4);
  assign sel_hit_o  = valid_i && legal_size && (addr_i == ADDR_W'(0));
  assign win_hit_o  = valid_i && legal_size && (addr_i == ADDR_W'(16));
  assign err_o      = valid_i && !(sel_hit_o || win_hit_o);
endmodule

// File: rtl/irq_index_decode.sv
module irq_index_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned ENT_W       = 5
) (
  input  logic [7:0]       idx_i,
  output reg_kind_e        kind_o,
  output logic [ENT_W-1:0] ent_o,
  output logic             upper_o
);
  localparam int unsigned TAB_END = 16 + 2 * NUM_ENTRIES;

  logic [7:0] off;

  assign off     = idx_i - IDX_TAB;
  assign upper_o = idx_i[0];

  always_comb begin
    kind_o = K_UNDEF;
    ent_o  = '0;
    if (idx_i == IDX_ID) begin
      kind_o = K_ID;
    end else if (idx_i == IDX_VER) begin
      kind_o = K_VER;
    end else if (idx_i == IDX_ARB) begin
      kind_o = K_ARB;
    end else if (idx_i >= IDX_TAB && 32'(idx_i) < TAB_END) begin
      kind_o = K_TAB;
      ent_o  = ENT_W'(off >> 1);
    end
  end
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] entry_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_o <= ENTRY_RST;
    end else begin
      if (wr_lo_i) entry_o[31:0]  <= wdata_i & LO_KEEP;
      if (wr_hi_i) entry_o[63:32] <= wdata_i & HI_KEEP;
    end
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_ENTRIES = 24,
  parameter int unsigned RESET_ID    = 0,
  parameter logic [7:0]  VERSION     = 8'h11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_valid_i,
  input  logic                        bus_write_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [2:0]                  bus_bytes_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic                        bus_err_o,
  output logic                        undef_reg_o,
  output logic [64*NUM_ENTRIES-1:0]   entries_o
);
  localparam int unsigned ENT_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam int unsigned MAX_IDX = NUM_ENTRIES - 1;
  localparam logic [31:0] VER_WORD = {8'h00, 8'(MAX_IDX), 8'h00, VERSION};

  logic             sel_hit, win_hit, win_wr;
  logic [7:0]       sel_q;
  logic [3:0]       id_q, arb_q;
  reg_kind_e        kind;
  logic [ENT_W-1:0] ent_idx;
  logic             upper;
  logic [63:0]      ent_w [NUM_ENTRIES];
  logic [63:0]      ent_sel;

  irq_bus_decode #(.ADDR_W(ADDR_W)) i_bus_decode (
    .valid_i   (bus_valid_i),
    .addr_i    (bus_addr_i),
    .bytes_i   (bus_bytes_i),
    .sel_hit_o (sel_hit),
    .win_hit_o (win_hit),
    .err_o     (bus_err_o)
  );

  irq_index_decode #(.NUM_ENTRIES(NUM_ENTRIES), .ENT_W(ENT_W)) i_index_decode (
    .idx_i   (sel_q),
    .kind_o  (kind),
    .ent_o   (ent_idx),
    .upper_o (upper)
  );

  assign win_wr = win_hit && bus_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= 4'(RESET_ID);
      arb_q <= 4'(RESET_ID);
    end else begin
      if (sel_hit && bus_write_i)       sel_q <= bus_wdata_i[7:0];
      if (win_wr && kind == K_ID)       id_q  <= bus_wdata_i[27:24];
      if (win_wr && kind == K_ARB)      arb_q <= bus_wdata_i[27:24];
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = win_wr && (kind == K_TAB) && (ent_idx == ENT_W'(g));
    irq_route_entry i_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (hit && !upper),
      .wr_hi_i (hit && upper),
      .wdata_i (bus_wdata_i),
      .entry_o (ent_w[g])
    );
    assign entries_o[g*64 +: 64] = ent_w[g];
  end

  // ent_idx stays in range whenever kind == K_TAB
  assign ent_sel = (kind == K_TAB) ? ent_w[ent_idx] : 64'h0;

  always_comb begin
    bus_rdata_o = '0;
    if (sel_hit && !bus_write_i) begin
      bus_rdata_o = {24'h0, sel_q};
    end else if (win_hit && !bus_write_i) begin
      unique case (kind)
        K_ID:    bus_rdata_o = {4'h0, id_q, 24'h0};
        K_VER:   bus_rdata_o = VER_WORD;
        K_ARB:   bus_rdata_o = {4'h0, arb_q, 24'h0};
        K_TAB:   bus_rdata_o = upper ? ent_sel[63:32] : ent_sel[31:0];
        default: bus_rdata_o = '0;
      endcase
    end
  end

  assign undef_reg_o = win_hit && (kind == K_UNDEF);
endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_ENTRIES = 24,
  parameter logic [7:0]  VERSION     = 8'h11
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      bus_valid_i,
  input logic                      bus_write_i,
  input logic [ADDR_W-1:0]         bus_addr_i,
  input logic [2:0]                bus_bytes_i,
  input logic [31:0]               bus_wdata_i,
  input logic [31:0]               bus_rdata_o,
  input logic                      bus_err_o,
  input logic                      undef_reg_o,
  input logic [64*NUM_ENTRIES-1:0] entries_o
);
  localparam logic [64*NUM_ENTRIES-1:0] KEEP_ALL = {NUM_ENTRIES{HI_KEEP, LO_KEEP}};
  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

  logic       legal, rd_sel, rd_win;
  logic [7:0] sel_sh;

  assign legal  = bus_valid_i && bus_bytes_i == 3'd4;
  assign rd_sel = legal && !bus_write_i && bus_addr_i == ADDR_W'(0);
  assign rd_win = legal && !bus_write_i && bus_addr_i == ADDR_W'(16);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_sh <= '0;
    else if (legal && bus_write_i && bus_addr_i == ADDR_W'(0)) sel_sh <= bus_wdata_i[7:0];
  end

  p_bad_size_err_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_bytes_i != 3'd4) |-> (bus_err_o && bus_rdata_o == 32'h0));

  p_err_no_change_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> $stable(entries_o));

  p_sel_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel |-> bus_rdata_o == {24'h0, sel_sh});

  p_ver_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_win && sel_sh == 8'h01) |-> bus_rdata_o == VER_EXP);

  p_reserved_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entries_o & ~KEEP_ALL) == '0);

  p_undef_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_reg_o |-> (bus_rdata_o == 32'h0 && !bus_err_o));

  p_undef_no_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_reg_o |=> $stable(entries_o));
endmodule

bind irq_route_regfile irq_route_regfile_chk #(
  .ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_bytes_i (bus_bytes_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .bus_err_o   (bus_err_o),
  .undef_reg_o (undef_reg_o),
  .entries_o   (entries_o)
);

// File: tb/test_irq_route_regfile.sv
module test_irq_route_regfile;
  localparam int N   = 24;
  localparam int RID = 5;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [7:0]      bus_addr_i = '0;
  logic [2:0]      bus_bytes_i = 3'd4;
  logic [31:0]     bus_wdata_i = '0;
  logic [31:0]     bus_rdata_o;
  logic            bus_err_o, undef_reg_o;
  logic [64*N-1:0] entries_o;

  always #4 clk_i = ~clk_i;

  irq_route_regfile #(.ADDR_W(8), .NUM_ENTRIES(N), .RESET_ID(RID), .VERSION(8'h11)) i_irq_route_regfile (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_bytes_i,
    .bus_wdata_i, .bus_rdata_o, .bus_err_o, .undef_reg_o, .entries_o
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_tab [N];
  logic [7:0]  m_sel;
  logic [3:0]  m_id, m_arb;

  function automatic logic [31:0] m_read(logic [7:0] idx);
    int i = int'(idx);
    if (i == 0) return {4'h0, m_id, 24'h0};
    if (i == 1) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
    if (i == 2) return {4'h0, m_arb, 24'h0};
    if (i >= 16 && i < 16 + 2 * N)
      return ((i - 16) % 2 == 1) ? m_tab[(i - 16) / 2][63:32] : m_tab[(i - 16) / 2][31:0];
    return 32'h0;
  endfunction

  function automatic bit m_undef(logic [7:0] idx);
    int i = int'(idx);
    return !(i <= 2 || (i >= 16 && i < 16 + 2 * N));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(bit w, logic [7:0] a, logic [2:0] b, logic [31:0] d, string req);
    bit legal;
    logic [31:0] exp_rd;
    int i;
    @(negedge clk_i);
    bus_valid_i = 1'b1; bus_write_i = w; bus_addr_i = a; bus_bytes_i = b; bus_wdata_i = d;
    #1;
    legal  = (b == 3'd4) && (a == 8'd0 || a == 8'd16);
    exp_rd = 32'h0;
    if (legal && !w) exp_rd = (a == 8'd0) ? {24'h0, m_sel} : m_read(m_sel);
    chk({req, " rdata"}, 64'(bus_rdata_o), 64'(exp_rd));
    chk({req, " err"}, 64'(bus_err_o), 64'(!legal));
    chk({req, " undef"}, 64'(undef_reg_o), 64'(legal && a == 8'd16 && m_undef(m_sel)));
    @(posedge clk_i);
    if (legal && w) begin
      i = int'(m_sel);
      if (a == 8'd0) m_sel = d[7:0];
      else if (i == 0) m_id = d[27:24];
      else if (i == 2) m_arb = d[27:24];
      else if (i >= 16 && i < 16 + 2 * N) begin
        if ((i - 16) % 2 == 1) m_tab[(i - 16) / 2][63:32] = d & 32'hFF00_0000;
        else                   m_tab[(i - 16) / 2][31:0]  = d & 32'h0001_AFFF;
      end
    end
    #1 bus_valid_i = 1'b0;
  endtask

  // compare every entry against the model on each falling edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit bad = 0;
      int first = -1;
      for (int n = 0; n < N; n++)
        if (entries_o[n*64 +: 64] !== m_tab[n] && !bad) begin bad = 1; first = n; end
      n_tests++;
      if (bad) begin
        n_fail++;
        $display("FAIL R6/R9 entries_o[%0d] act=%h exp=%h", first,
                 entries_o[first*64 +: 64], m_tab[first]);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int n = 0; n < N; n++) m_tab[n] = 64'h0000_0000_0001_0000;
    m_sel = 8'h00; m_id = 4'(RID); m_arb = 4'(RID);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R8 reset entry0", entries_o[63:0], 64'h0000_0000_0001_0000);
    chk("R8 reset entry last", entries_o[(N-1)*64 +: 64], 64'h0000_0000_0001_0000);

    acc(0, 8'd0, 3'd4, 0, "R2 reset select");
    acc(0, 8'd16, 3'd4, 0, "R3 reset id");
    acc(1, 8'd0, 3'd4, 32'hFFFF_FF01, "R2 write select");
    acc(0, 8'd0, 3'd4, 0, "R2 read select");
    acc(0, 8'd16, 3'd4, 0, "R4 version");
    acc(1, 8'd16, 3'd4, 32'hFFFF_FFFF, "R4 write ignored");
    acc(0, 8'd16, 3'd4, 0, "R4 version after write");
    acc(1, 8'd0, 3'd4, 32'h2, "R5 select arb");
    acc(0, 8'd16, 3'd4, 0, "R5 reset arb");
    acc(1, 8'd16, 3'd4, 32'hFAFF_FFFF, "R5 write arb");
    acc(0, 8'd16, 3'd4, 0, "R5 read arb");
    acc(1, 8'd0, 3'd4, 32'h0, "R3 select id");
    acc(1, 8'd16, 3'd4, 32'hFFFF_FFFF, "R3 write id");
    acc(0, 8'd16, 3'd4, 0, "R3 read id");

    acc(1, 8'd0, 3'd4, 32'h10, "R7 select lo0");
    acc(0, 8'd16, 3'd4, 0, "R8 reset lo0");
    acc(1, 8'd16, 3'd4, 32'hFFFF_FFFF, "R7 write lo ones");
    acc(0, 8'd16, 3'd4, 0, "R7 read lo ones");
    acc(1, 8'd0, 3'd4, 32'h11, "R7 select hi0");
    acc(1, 8'd16, 3'd4, 32'hFFFF_FFFF, "R7 write hi ones");
    acc(0, 8'd16, 3'd4, 0, "R7 read hi ones");

    for (int n = 0; n < N; n++) begin
      acc(1, 8'd0, 3'd4, 32'(16 + 2 * n), "R6 select lo");
      acc(1, 8'd16, 3'd4, 32'h5A5A_0000 ^ (32'(n) * 32'h0103_0507), "R6 write lo");
      acc(1, 8'd0, 3'd4, 32'(17 + 2 * n), "R6 select hi");
      acc(1, 8'd16, 3'd4, 32'hA500_0000 ^ (32'(n) << 24), "R6 write hi");
    end
    for (int n = 0; n < N; n++) begin
      acc(1, 8'd0, 3'd4, 32'(16 + 2 * n), "R6 select lo rb");
      acc(0, 8'd16, 3'd4, 0, "R6/R10 read lo");
      acc(1, 8'd0, 3'd4, 32'(17 + 2 * n), "R6 select hi rb");
      acc(0, 8'd16, 3'd4, 0, "R6/R10 read hi");
    end

    acc(1, 8'd0, 3'd4, 32'(16 + 2 * N), "R9 select first undefined");
    acc(1, 8'd16, 3'd4, 32'hFFFF_FFFF, "R9 write undefined");
    acc(0, 8'd16, 3'd4, 0, "R9 read undefined");
    acc(1, 8'd0, 3'd4, 32'h5, "R9 select gap");
    acc(0, 8'd16, 3'd4, 0, "R9 read gap");
    acc(1, 8'd16, 3'd4, 32'h1234_5678, "R9 write gap");
    acc(1, 8'd0, 3'd4, 32'hFF, "R9 select top");
    acc(0, 8'd16, 3'd4, 0, "R9 read top");

    acc(1, 8'd0, 3'd4, 32'h11, "R1 select hi0");
    acc(1, 8'd4, 3'd4, 32'hFFFF_FFFF, "R1 bad offset write");
    acc(0, 8'd8, 3'd4, 0, "R1 bad offset read");
    acc(1, 8'd16, 3'd2, 32'h0000_0000, "R1 bad size window");
    acc(1, 8'd0, 3'd1, 32'h0000_0002, "R1 bad size select");
    acc(0, 8'd0, 3'd4, 0, "R1 select unchanged");
    acc(0, 8'd16, 3'd4, 0, "R1 entry unchanged");

    @(negedge clk_i);
    finish_run();
  end
endmodule